// File: doc/BRIEF.md
# Oscillator with Timed Phase Snapshot

This block is a numerically controlled oscillator. A 32-bit phase register grows by a programmable step on every clock and wraps around naturally. The top ten bits of that register index a full-cycle sine table. The table returns 12-bit signed samples, which go out on a port meant for an external DAC. Software or a control loop sets the step through a load strobe. A new step takes effect on the next edge and leaves the running phase where it is.

A timing pulse can arrive at any moment, for example a once-per-second reference. It enters the clock domain through a chain of flip-flops. When the synchronised pulse goes from low to high, the block takes a copy of the phase register. At the same moment it stores a fine-delay word from an outside time-interval measurement beside that copy. Software can then combine the coarse phase with the fine delay. This matters because the synchroniser alone leaves about two clocks of uncertainty.

A valid flag marks a stored snapshot and stays set until a clear strobe. A further edge that arrives before the clear replaces the snapshot and sets an overrun flag.

Top module: `nco_cap`

## Requirements
- R1: Every clock, the phase register adds the active step word, modulo 2^32. Reset sets both the phase and the active step to zero.
- R2: sample_out equals round(2047 * sin(2*pi*a/1024)), where a is bits 31..22 of the phase register as it stood one clock earlier. So a = 256 gives +2047 and a = 768 gives -2047.
- R3: Suppose pulse_in is first seen high at rising edge k. Then after edge k+2, cap_phase holds the value the phase register had after edge k+1. This is two synchroniser stages followed by one capture register.
- R4: No snapshot is taken while pulse_in stays high or when it falls. cap_phase and cap_fine stay unchanged until the next rising transition.
- R5: cap_fine receives the value on fine_in at the same edge that loads cap_phase.
- R6: A snapshot sets cap_valid to 1, and the flag stays 1 until cap_clear. cap_clear without a coincident snapshot sets both cap_valid and cap_overrun to 0 on the next edge.
- R7: A snapshot that arrives while cap_valid is 1, with no cap_clear, overwrites cap_phase and cap_fine and sets cap_overrun to 1. cap_overrun then stays 1 until cleared.
- R8: When a snapshot and cap_clear fall in the same cycle, the snapshot wins. cap_valid ends at 1 and cap_overrun ends at 0.
- R9: A step word presented with ftw_load becomes the active step on that edge. The phase register uses it from the following edge on, and the phase is not reset. A step of zero holds the phase constant.
- R10: Synchronous reset sets cap_phase, cap_fine, cap_valid, cap_overrun, sample_out, the synchroniser stages and the phase register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| ftw_in | input | 32 | Step (tuning) word |
| ftw_load | input | 1 | Load strobe for ftw_in |
| pulse_in | input | 1 | Asynchronous timing pulse |
| fine_in | input | 8 | Fine-delay word from an external interval meter |
| cap_clear | input | 1 | Acknowledge strobe for the snapshot flags |
| sample_out | output | 12 | Signed sine sample for the DAC |
| cap_phase | output | 32 | Captured phase register value |
| cap_fine | output | 8 | Fine-delay word stored with the snapshot |
| cap_valid | output | 1 | Snapshot present and not yet acknowledged |
| cap_overrun | output | 1 | Snapshot replaced before acknowledgement |

## Verification
Two cases can land in the same cycle and need care. The first is a snapshot edge together with a clear strobe. The bench raises cap_clear in exactly the clock where the synchronised edge appears, two edges after the pulse is seen. It expects the fresh snapshot to survive, with valid set and overrun clear. The second is a step reload together with a snapshot. The bench loads a new step, including zero, while pulses are pending. A reference phase model must then match every captured value and every sine sample on the cycle-exact schedule above.

// File: rtl/nco_cap_pkg.sv
package nco_cap_pkg;
    parameter int ACC_W     = 32;
    parameter int ADDR_W    = 10;
    parameter int SAMP_W    = 12;
    parameter int FINE_W    = 8;
    localparam int TBL_DEPTH = 1 << ADDR_W;
    localparam int AMPL      = (1 << (SAMP_W - 1)) - 1;

    typedef logic [ACC_W-1:0]         acc_t;
    typedef logic [ADDR_W-1:0]        addr_t;
    typedef logic signed [SAMP_W-1:0] samp_t;
    typedef logic [FINE_W-1:0]        fine_t;

    typedef struct packed {
        acc_t  phase;
        fine_t fine;
    } snap_t;

    typedef struct packed {
        logic valid;
        logic overrun;
    } snap_flags_t;

    function automatic samp_t sine_value(int idx);
        real x;
        int  r;
        x = real'(AMPL) * $sin(2.0 * 3.14159265358979 * real'(idx) / real'(TBL_DEPTH));
        r = (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
        return samp_t'(r);
    endfunction
endpackage

// File: rtl/nco_cap_sync.sv
module nco_cap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    localparam int N = (STAGES < 2) ? 2 : STAGES;

    logic [N-1:0] chain;
    logic         last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain  <= '0;
            last_q <= 1'b0;
        end else begin
            chain  <= {chain[N-2:0], async_in};
            last_q <= chain[N-1];
        end
    end

    assign rise = chain[N-1] & ~last_q;
endmodule

// File: rtl/nco_cap_acc.sv
module nco_cap_acc
    import nco_cap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  acc_t step_in,
    input  logic step_load,
    output acc_t phase_q,
    output acc_t step_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            step_q  <= '0;
        end else begin
            phase_q <= phase_q + step_q;
            if (step_load) step_q <= step_in;
        end
    end
endmodule

// File: rtl/nco_cap_sine.sv
module nco_cap_sine
    import nco_cap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  addr_t addr,
    output samp_t sample
);
    samp_t table_rom [TBL_DEPTH];

    initial begin
        for (int i = 0; i < TBL_DEPTH; i++) table_rom[i] = sine_value(i);
    end

    always_ff @(posedge clk) begin
        if (rst) sample <= '0;
        else     sample <= table_rom[addr];
    end
endmodule

// File: rtl/nco_cap_capture.sv
module nco_cap_capture
    import nco_cap_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        take,
    input  logic        clear,
    input  acc_t        phase_in,
    input  fine_t       fine_in,
    output snap_t       snap_q,
    output snap_flags_t flags_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q  <= '0;
            flags_q <= '0;
        end else if (take) begin
            snap_q.phase    <= phase_in;
            snap_q.fine     <= fine_in;
            flags_q.valid   <= 1'b1;
            flags_q.overrun <= clear ? 1'b0 : (flags_q.overrun | flags_q.valid);
        end else if (clear) begin
            flags_q <= '0;
        end
    end
endmodule

// File: rtl/nco_cap.sv
module nco_cap
    import nco_cap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ACC_W-1:0]  ftw_in,
    input  logic              ftw_load,
    input  logic              pulse_in,
    input  logic [FINE_W-1:0] fine_in,
    input  logic              cap_clear,
    output logic [SAMP_W-1:0] sample_out,
    output logic [ACC_W-1:0]  cap_phase,
    output logic [FINE_W-1:0] cap_fine,
    output logic              cap_valid,
    output logic              cap_overrun
);
    acc_t        acc_q;
    acc_t        ftw_q;
    logic        cap_edge;
    samp_t       samp;
    snap_t       snap;
    snap_flags_t flags;

    nco_cap_acc u_acc (
        .clk(clk), .rst(rst), .step_in(ftw_in), .step_load(ftw_load),
        .phase_q(acc_q), .step_q(ftw_q)
    );

    nco_cap_sine u_sine (
        .clk(clk), .rst(rst), .addr(acc_q[ACC_W-1 -: ADDR_W]), .sample(samp)
    );

    nco_cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(pulse_in), .rise(cap_edge)
    );

    nco_cap_capture u_cap (
        .clk(clk), .rst(rst), .take(cap_edge), .clear(cap_clear),
        .phase_in(acc_q), .fine_in(fine_in), .snap_q(snap), .flags_q(flags)
    );

    assign sample_out  = samp;
    assign cap_phase   = snap.phase;
    assign cap_fine    = snap.fine;
    assign cap_valid   = flags.valid;
    assign cap_overrun = flags.overrun;
endmodule

// File: rtl/nco_cap_chk.sv
module nco_cap_chk
    import nco_cap_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  ftw_load,
    input acc_t  ftw_in,
    input acc_t  acc_q,
    input acc_t  ftw_q,
    input logic  cap_edge,
    input logic  cap_clear,
    input fine_t fine_in,
    input acc_t  cap_phase,
    input fine_t cap_fine,
    input logic  cap_valid,
    input logic  cap_overrun
);
    // R1
    acc_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> acc_q == $past(acc_q + ftw_q));

    // R9
    ftw_load_chk: assert property (@(posedge clk) disable iff (rst)
        ftw_load |=> ftw_q == $past(ftw_in));

    // R3
    capture_phase_chk: assert property (@(posedge clk) disable iff (rst)
        cap_edge |=> cap_phase == $past(acc_q));

    // R5
    capture_fine_chk: assert property (@(posedge clk) disable iff (rst)
        cap_edge |=> cap_fine == $past(fine_in));

    // R4
    no_edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cap_edge |=> $stable(cap_phase) && $stable(cap_fine));

    // R6
    valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cap_valid && !cap_clear |=> cap_valid);

    // R6
    clear_only_chk: assert property (@(posedge clk) disable iff (rst)
        cap_clear && !cap_edge |=> !cap_valid && !cap_overrun);

    // R7
    overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
        cap_edge && cap_valid && !cap_clear |=> cap_overrun);

    // R8
    clear_vs_edge_chk: assert property (@(posedge clk) disable iff (rst)
        cap_edge && cap_clear |=> cap_valid && !cap_overrun);
endmodule

bind nco_cap nco_cap_chk u_chk (
    .clk(clk), .rst(rst), .ftw_load(ftw_load), .ftw_in(ftw_in),
    .acc_q(acc_q), .ftw_q(ftw_q), .cap_edge(cap_edge), .cap_clear(cap_clear),
    .fine_in(fine_in), .cap_phase(cap_phase), .cap_fine(cap_fine),
    .cap_valid(cap_valid), .cap_overrun(cap_overrun)
);

// File: tb/nco_cap_bench.sv
module nco_cap_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ftw_in = '0;
    logic        ftw_load = 1'b0;
    logic        pulse_in = 1'b0;
    logic [7:0]  fine_in = '0;
    logic        cap_clear = 1'b0;
    logic [11:0] sample_out;
    logic [31:0] cap_phase;
    logic [7:0]  cap_fine;
    logic        cap_valid;
    logic        cap_overrun;

    nco_cap u_nco_cap (
        .clk(clk), .rst(rst), .ftw_in(ftw_in), .ftw_load(ftw_load),
        .pulse_in(pulse_in), .fine_in(fine_in), .cap_clear(cap_clear),
        .sample_out(sample_out), .cap_phase(cap_phase), .cap_fine(cap_fine),
        .cap_valid(cap_valid), .cap_overrun(cap_overrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad = 0;
    int unsigned cyc = 0;
    logic [31:0] m_acc = '0;
    logic [31:0] m_ftw = '0;
    logic [11:0] m_samp = '0;

    typedef struct {
        int unsigned due;
        logic [31:0] ph;
        logic [7:0]  fn;
        bit          ovr;
        string       tag;
    } item_t;
    item_t q[$];

    function automatic logic [11:0] sine_ref(logic [31:0] a);
        real x;
        int  r;
        x = 2047.0 * $sin(2.0 * 3.14159265358979 * real'(a[31:22]) / 1024.0);
        r = (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
        return 12'(r);
    endfunction

    // reference model for R1, R2, R9
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            m_acc  <= '0;
            m_ftw  <= '0;
            m_samp <= '0;
        end else begin
            m_acc  <= m_acc + m_ftw;
            m_samp <= sine_ref(m_acc);
            if (ftw_load) m_ftw <= ftw_in;
        end
    end

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // monitor: sine every cycle (R2), snapshots when due (R3, R5, R6, R7, R8)
    always @(negedge clk) begin
        chk(sample_out == m_samp, "R2", "sample_out", sample_out, m_samp);
        if (q.size() > 0 && q[0].due == cyc) begin
            item_t it;
            it = q.pop_front();
            chk(cap_phase == it.ph, it.tag, "cap_phase", cap_phase, it.ph);
            chk(cap_fine == it.fn, "R5", "cap_fine", cap_fine, it.fn);
            chk(cap_valid == 1'b1, "R6", "cap_valid", cap_valid, 1);
            chk(cap_overrun == it.ovr, it.ovr ? "R7" : "R8", "cap_overrun", cap_overrun, it.ovr);
        end
    end

    task automatic load_ftw(logic [31:0] w);
        @(negedge clk); ftw_in = w; ftw_load = 1'b1;
        @(negedge clk); ftw_load = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // driver: one pulse, expected snapshot pushed to the scoreboard
    task automatic pulse(logic [7:0] fn, bit exp_ovr, bit with_clear, bit keep_high, string tag);
        @(negedge clk); fine_in = fn; pulse_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        q.push_back('{due: cyc + 1, ph: m_acc, fn: fn, ovr: exp_ovr, tag: tag});
        if (with_clear) cap_clear = 1'b1;
        @(negedge clk);
        cap_clear = 1'b0;
        if (!keep_high) pulse_in = 1'b0;
        fine_in = ~fn;
        @(negedge clk);
    endtask

    task automatic clear_flags();
        @(negedge clk); cap_clear = 1'b1;
        @(negedge clk); cap_clear = 1'b0;
        chk(cap_valid == 1'b0, "R6", "cap_valid after clear", cap_valid, 0);
        chk(cap_overrun == 1'b0, "R6", "cap_overrun after clear", cap_overrun, 0);
    endtask

    bit done = 0;
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            chk(1'b0, "WATCHDOG", "timeout", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] held_ph;
        idle(3);
        // R10 reset state
        chk(cap_phase == 0, "R10", "cap_phase reset", cap_phase, 0);
        chk(cap_valid == 0, "R10", "cap_valid reset", cap_valid, 0);
        chk(sample_out == 0, "R10", "sample_out reset", sample_out, 0);
        rst = 1'b0;

        // R1 R9: step and random pulse offsets
        load_ftw(32'h0123_4567);
        for (int i = 0; i < 6; i++) begin
            idle(1 + ($urandom % 37));
            pulse(8'(i * 29 + 3), 1'b0, 1'b0, 1'b0, "R3");
            clear_flags();
        end

        // R4: held high then falling, no new snapshot
        pulse(8'h5A, 1'b0, 1'b0, 1'b1, "R4");
        held_ph = cap_phase;
        idle(20);
        chk(cap_phase == held_ph, "R4", "phase while held", cap_phase, held_ph);
        pulse_in = 1'b0;
        idle(6);
        chk(cap_phase == held_ph, "R4", "phase after fall", cap_phase, held_ph);
        chk(cap_fine == 8'h5A, "R4", "fine after fall", cap_fine, 8'h5A);

        // R7: second snapshot before clear
        pulse(8'h11, 1'b1, 1'b0, 1'b0, "R7");
        idle(4);
        chk(cap_overrun == 1'b1, "R7", "overrun sticky", cap_overrun, 1);
        clear_flags();

        // R8: edge coincident with clear
        pulse(8'h22, 1'b0, 1'b0, 1'b0, "R3");
        pulse(8'h33, 1'b0, 1'b1, 1'b0, "R8");

        // R9: wrapping step, then zero step freezes phase
        clear_flags();
        load_ftw(32'hF00F_0001);
        idle(13);
        pulse(8'h44, 1'b0, 1'b0, 1'b0, "R9");
        clear_flags();
        load_ftw(32'h0);
        idle(3);
        held_ph = m_acc;
        pulse(8'h55, 1'b0, 1'b0, 1'b0, "R9");
        chk(cap_phase == held_ph, "R9", "frozen phase", cap_phase, held_ph);
        load_ftw(32'h0400_0000);
        idle(300);

        // R10 reset mid-run
        @(negedge clk); rst = 1'b1;
        idle(2);
        chk(cap_phase == 0, "R10", "cap_phase rerun", cap_phase, 0);
        chk(cap_valid == 0 && cap_overrun == 0, "R10", "flags rerun", {cap_valid, cap_overrun}, 0);
        chk(sample_out == 0, "R10", "sample rerun", sample_out, 0);
        rst = 1'b0;
        idle(5);
        chk(q.size() == 0, "R3", "scoreboard drained", q.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule